// File: doc/BRIEF.md
# MMU Fault Classifier and Register Update

This block sits behind the address-translation lookup of a 32-bit processor core. For each access it receives the virtual address, the access direction, the privilege and error-level state, and the two-bit outcome of the translation buffer lookup. It decides whether the access faults. On a fault it produces the exception code, the refill flag, and the new values of the Context and EntryHi coprocessor registers.

The segment check is done here. A user-mode access to the upper half of the address space is an address error, and the lookup outcome is then ignored. Only the lower half, with the error-level flag clear, is translated. Any other access needs no translation and never faults here.

Results are registered. They appear one clock after the access is presented, with a fault strobe that lasts one cycle. The register outputs keep their last value until the next fault.

Top module: `mmu_fault_unit`

## Requirements
- R1: When `user_mode` is 1 and `vaddr[31]` is 1, the access faults with code 4 (address error, load) when `is_write` is 0, or code 5 (address error, store) when it is 1, and `refill` is 0, whatever `tlb_result` is.
- R2: A translated access is one with `vaddr[31]`=0 and `err_level`=0. For a translated access with `tlb_result`=2'b01 (no match), the code is 2 (TLB load) on a read or 3 (TLB store) on a write, with `refill`=1.
- R3: For a translated access with `tlb_result`=2'b10 (entry not valid), the code is 2 on a read or 3 on a write, with `refill`=0.
- R4: For a translated access with `tlb_result`=2'b11 (write to a clean page), the code is 1 (modified) for either direction, with `refill`=0.
- R5: For a translated access with `tlb_result`=2'b00 (match), there is no fault, and `context_out` and `entryhi_out` keep their previous values.
- R6: When `err_level` is 1, an access with `vaddr[31]`=0 does not fault, whatever `tlb_result` is.
- R7: A kernel-mode access (`user_mode`=0) with `vaddr[31]`=1 does not fault, whatever `tlb_result` is.
- R8: On a fault, `context_out[31:23]` equals `context_in[31:23]`, `context_out[22:4]` equals `vaddr[31:13]`, and `context_out[3:0]` is 0.
- R9: On a fault, `entryhi_out[31:13]` equals `vaddr[31:13]`, `entryhi_out[12:8]` is 0, and `entryhi_out[7:0]` equals `entryhi_in[7:0]`.
- R10: `fault_valid` is high for exactly the one cycle after a faulting access is sampled with `acc_valid`=1. With `acc_valid`=0 there is no strobe, and all outputs keep their values, except that `exc_code` and `refill` are 0 when `fault_valid` is 0.
- R11: During reset and right after it, `fault_valid`, `exc_code`, `refill`, `context_out` and `entryhi_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address of the access |
| is_write | input | 1 | 1 for a store, 0 for a load |
| user_mode | input | 1 | The core is in user mode |
| err_level | input | 1 | The error-level flag is set (translation bypassed) |
| tlb_result | input | 2 | Lookup outcome: 00 match, 01 no match, 10 not valid, 11 clean page |
| context_in | input | 32 | Current Context register value |
| entryhi_in | input | 32 | Current EntryHi register value |
| fault_valid | output | 1 | One-cycle fault strobe |
| exc_code | output | 5 | Exception code of the fault, 0 when there is none |
| refill | output | 1 | The fault is a refill (no matching entry) |
| context_out | output | 32 | New Context value, updated on a fault |
| entryhi_out | output | 32 | New EntryHi value, updated on a fault |

## Verification
The hardest cases to reach are the ones where a forceful lookup outcome must lose to the segment logic. Examples are a clean-page result on a user access above the boundary, or a no-match result while the error level is set. There, a wrong priority gives a plausible but wrong code, or a spurious strobe.

The stimulus pairs each such segment case with the lookup outcome most likely to leak through. It also straddles the boundary with 0x7FFFFFFF and 0x80000000 in user mode. Faults are placed directly after a match and after idle cycles, with different register inputs each time, so that a held value can be told apart from a freshly loaded one.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

  // Two-bit outcome of the translation lookup
  typedef enum logic [1:0] {
    TLB_HIT   = 2'd0,
    TLB_MISS  = 2'd1,
    TLB_INVAL = 2'd2,
    TLB_CLEAN = 2'd3
  } tlb_res_e;

  // Exception codes raised by this block
  typedef enum logic [4:0] {
    EXC_NONE = 5'd0,
    EXC_MOD  = 5'd1,
    EXC_TLBL = 5'd2,
    EXC_TLBS = 5'd3,
    EXC_ADEL = 5'd4,
    EXC_ADES = 5'd5
  } exc_e;

  typedef struct packed {
    logic fault;
    exc_e code;
    logic refill;
  } verdict_t;

endpackage

// File: rtl/mmu_seg_check.sv
module mmu_seg_check (
  input  logic addr_msb,
  input  logic user_mode,
  input  logic err_level,
  output logic bad_addr,
  output logic needs_tlb
);

  // The upper half of the space is closed to user mode
  always_comb begin
    bad_addr  = user_mode & addr_msb;
    needs_tlb = ~addr_msb & ~err_level;
  end

endmodule

// File: rtl/mmu_fault_classify.sv
module mmu_fault_classify
  import mmu_fault_pkg::*;
(
  input  logic     bad_addr,
  input  logic     needs_tlb,
  input  logic     is_write,
  input  tlb_res_e tlb_res,
  output verdict_t verdict
);

  // Priority: segment error first, then the lookup outcome on translated accesses
  always_comb begin
    verdict = '{fault: 1'b0, code: EXC_NONE, refill: 1'b0};
    if (bad_addr) begin
      verdict.fault = 1'b1;
      verdict.code  = is_write ? EXC_ADES : EXC_ADEL;
    end else if (needs_tlb) begin
      unique case (tlb_res)
        TLB_HIT: ;
        TLB_MISS: begin
          verdict.fault  = 1'b1;
          verdict.code   = is_write ? EXC_TLBS : EXC_TLBL;
          verdict.refill = 1'b1;
        end
        TLB_INVAL: begin
          verdict.fault = 1'b1;
          verdict.code  = is_write ? EXC_TLBS : EXC_TLBL;
        end
        TLB_CLEAN: begin
          verdict.fault = 1'b1;
          verdict.code  = EXC_MOD;
        end
        default: ;
      endcase
    end
  end

  // R2 and R3 share codes; only a miss may carry the refill mark
  always_comb begin
    if (verdict.refill) begin
      a_r2_refill_only_on_miss: assert (verdict.fault && tlb_res == TLB_MISS && !bad_addr);
    end
  end

endmodule

// File: rtl/mmu_reg_update.sv
module mmu_reg_update #(
  parameter int ADDR_W      = 32,
  parameter int ASID_W      = 8,
  parameter int VPN2_LSB    = 13,
  parameter int CTX_VPN_LSB = 4
) (
  input  logic [ADDR_W-1:VPN2_LSB]                           vpn2,
  input  logic [ADDR_W-1:CTX_VPN_LSB+(ADDR_W-VPN2_LSB)]      ctx_keep,
  input  logic [ASID_W-1:0]                                  asid,
  output logic [ADDR_W-1:0]                                  ctx_next,
  output logic [ADDR_W-1:0]                                  ehi_next
);

  localparam int VPN_W        = ADDR_W - VPN2_LSB;
  localparam int CTX_HOLD_LSB = CTX_VPN_LSB + VPN_W;

  always_comb begin
    ctx_next = '0;
    ctx_next[ADDR_W-1:CTX_HOLD_LSB]      = ctx_keep;
    ctx_next[CTX_HOLD_LSB-1:CTX_VPN_LSB] = vpn2;
  end

  always_comb begin
    ehi_next = '0;
    ehi_next[ADDR_W-1:VPN2_LSB] = vpn2;
    ehi_next[ASID_W-1:0]        = asid;
  end

endmodule

// File: rtl/mmu_fault_unit.sv
module mmu_fault_unit
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ASID_W      = 8,
  parameter int PAGE_BITS   = 12,
  parameter int CTX_VPN_LSB = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_write,
  input  logic              user_mode,
  input  logic              err_level,
  input  logic [1:0]        tlb_result,
  input  logic [ADDR_W-1:0] context_in,
  input  logic [ADDR_W-1:0] entryhi_in,
  output logic              fault_valid,
  output logic [4:0]        exc_code,
  output logic              refill,
  output logic [ADDR_W-1:0] context_out,
  output logic [ADDR_W-1:0] entryhi_out
);

  localparam int VPN2_LSB     = PAGE_BITS + 1;
  localparam int VPN_W        = ADDR_W - VPN2_LSB;
  localparam int CTX_HOLD_LSB = CTX_VPN_LSB + VPN_W;

  // Reset: asserted at once, released through a synchronizer chain
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // Segment check
  logic bad_addr, needs_tlb;
  mmu_seg_check u_seg (
    .addr_msb  (vaddr[ADDR_W-1]),
    .user_mode (user_mode),
    .err_level (err_level),
    .bad_addr  (bad_addr),
    .needs_tlb (needs_tlb)
  );

  // Classification
  verdict_t verdict;
  mmu_fault_classify u_cls (
    .bad_addr  (bad_addr),
    .needs_tlb (needs_tlb),
    .is_write  (is_write),
    .tlb_res   (tlb_res_e'(tlb_result)),
    .verdict   (verdict)
  );

  // Register images
  logic [ADDR_W-1:0] ctx_next, ehi_next;
  mmu_reg_update #(
    .ADDR_W      (ADDR_W),
    .ASID_W      (ASID_W),
    .VPN2_LSB    (VPN2_LSB),
    .CTX_VPN_LSB (CTX_VPN_LSB)
  ) u_upd (
    .vpn2     (vaddr[ADDR_W-1:VPN2_LSB]),
    .ctx_keep (context_in[ADDR_W-1:CTX_HOLD_LSB]),
    .asid     (entryhi_in[ASID_W-1:0]),
    .ctx_next (ctx_next),
    .ehi_next (ehi_next)
  );

  logic [VPN2_LSB+CTX_HOLD_LSB+(ADDR_W-ASID_W)-1:0] unused_bits;
  assign unused_bits = {vaddr[VPN2_LSB-1:0], context_in[CTX_HOLD_LSB-1:0],
                        entryhi_in[ADDR_W-1:ASID_W]};

  // Next state
  logic              fault_d;
  logic [4:0]        code_d;
  logic              refill_d;
  logic [ADDR_W-1:0] ctx_d, ehi_d;
  logic              reg_en;

  always_comb begin
    fault_d  = acc_valid & verdict.fault;
    code_d   = fault_d ? verdict.code : EXC_NONE;
    refill_d = fault_d & verdict.refill;
    reg_en   = fault_d;
    ctx_d    = reg_en ? ctx_next : context_out;
    ehi_d    = reg_en ? ehi_next : entryhi_out;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fault_valid <= 1'b0;
      exc_code    <= '0;
      refill      <= 1'b0;
    end else begin
      fault_valid <= fault_d;
      exc_code    <= code_d;
      refill      <= refill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      context_out <= '0;
      entryhi_out <= '0;
    end else if (reg_en) begin
      context_out <= ctx_d;
      entryhi_out <= ehi_d;
    end
  end

  // Assertions
  a_r1_user_high_is_addr_err: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) && $past(acc_valid && user_mode && vaddr[ADDR_W-1])
      |-> fault_valid && !refill && (exc_code == EXC_ADEL || exc_code == EXC_ADES));

  a_r2_refill_is_tlb_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    refill |-> fault_valid && (exc_code == EXC_TLBL || exc_code == EXC_TLBS));

  a_r4_clean_page_is_mod: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) && $past(acc_valid && !vaddr[ADDR_W-1] && !err_level &&
                               tlb_result == 2'b11)
      |-> fault_valid && exc_code == EXC_MOD);

  a_r5_regs_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fault_valid |-> $stable(context_out) && $stable(entryhi_out));

  a_r6_r7_unmapped_silent: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) && $past(!bad_addr && !needs_tlb) |-> !fault_valid);

  a_r9_asid_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) && fault_valid
      |-> entryhi_out[ASID_W-1:0] == $past(entryhi_in[ASID_W-1:0]));

  a_r10_strobe_needs_access: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) && fault_valid |-> $past(acc_valid));

  a_r10_code_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fault_valid |-> exc_code == '0 && !refill);

endmodule

// File: tb/mmu_fault_unit_tb_top.sv
module mmu_fault_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] vaddr;
  logic        is_write, user_mode, err_level;
  logic [1:0]  tlb_result;
  logic [31:0] context_in, entryhi_in;
  logic        fault_valid;
  logic [4:0]  exc_code;
  logic        refill;
  logic [31:0] context_out, entryhi_out;

  always #5 clk = ~clk;

  mmu_fault_unit dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .vaddr(vaddr),
    .is_write(is_write), .user_mode(user_mode), .err_level(err_level),
    .tlb_result(tlb_result), .context_in(context_in), .entryhi_in(entryhi_in),
    .fault_valid(fault_valid), .exc_code(exc_code), .refill(refill),
    .context_out(context_out), .entryhi_out(entryhi_out)
  );

  typedef struct {
    logic        fault;
    logic [4:0]  code;
    logic        refill;
    logic [31:0] ctx;
    logic [31:0] ehi;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;
  logic [31:0] m_ctx = '0;
  logic [31:0] m_ehi = '0;

  // Driver: present one cycle of stimulus and push its expected result
  task automatic drive(input logic v, input logic [31:0] va, input logic wr,
                       input logic um, input logic erl, input logic [1:0] res,
                       input logic [31:0] ci, input logic [31:0] ei, input string req);
    exp_t e;
    logic flt;
    logic [4:0] cd;
    logic rf;
    @(negedge clk);
    acc_valid = v; vaddr = va; is_write = wr; user_mode = um;
    err_level = erl; tlb_result = res; context_in = ci; entryhi_in = ei;
    flt = 1'b0; cd = 5'd0; rf = 1'b0;
    if (um && va[31]) begin                       // R1
      flt = 1'b1; cd = wr ? 5'd5 : 5'd4;
    end else if (!va[31] && !erl) begin           // R2..R5
      case (res)
        2'b01: begin flt = 1'b1; cd = wr ? 5'd3 : 5'd2; rf = 1'b1; end
        2'b10: begin flt = 1'b1; cd = wr ? 5'd3 : 5'd2; end
        2'b11: begin flt = 1'b1; cd = 5'd1; end
        default: ;
      endcase
    end                                           // R6, R7: no fault
    if (!v) begin flt = 1'b0; cd = 5'd0; rf = 1'b0; end  // R10
    if (flt) begin                                // R8, R9
      m_ctx = {ci[31:23], va[31:13], 4'b0000};
      m_ehi = {va[31:13], 5'b00000, ei[7:0]};
    end
    e.fault = flt; e.code = cd; e.refill = rf; e.ctx = m_ctx; e.ehi = m_ehi; e.req = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compare one cycle after each driven cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (fault_valid !== e.fault || exc_code !== e.code || refill !== e.refill ||
          context_out !== e.ctx || entryhi_out !== e.ehi) begin
        n_fail++;
        $display("FAIL %s: got flt=%0b code=%0d rf=%0b ctx=%h ehi=%h, expected flt=%0b code=%0d rf=%0b ctx=%h ehi=%h",
                 e.req, fault_valid, exc_code, refill, context_out, entryhi_out,
                 e.fault, e.code, e.refill, e.ctx, e.ehi);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acc_valid = 0; vaddr = '0; is_write = 0; user_mode = 0;
    err_level = 0; tlb_result = 2'b00; context_in = '0; entryhi_in = '0;
    repeat (3) @(negedge clk);
    n_checks++;                                   // R11 during reset
    if (fault_valid !== 0 || exc_code !== 0 || refill !== 0 ||
        context_out !== 0 || entryhi_out !== 0) begin
      n_fail++;
      $display("FAIL R11: got flt=%0b code=%0d ctx=%h ehi=%h, expected all zero",
               fault_valid, exc_code, context_out, entryhi_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(0, 32'h0, 0, 0, 0, 2'b00, 32'h0, 32'h0, "R11");

    // R1: user access to the upper half, lookup outcome ignored
    drive(1, 32'h8000_1234, 0, 1, 0, 2'b01, 32'hFF80_0000, 32'h0000_0011, "R1");
    drive(1, 32'h8000_1234, 1, 1, 0, 2'b00, 32'h1234_5678, 32'hABCD_EF22, "R1");
    drive(1, 32'hFFFF_F000, 1, 1, 0, 2'b11, 32'hA5A5_A5A5, 32'h0000_0033, "R1");
    drive(1, 32'h8000_0000, 0, 1, 1, 2'b00, 32'h0F0F_0F0F, 32'h0000_0044, "R1");
    // R2: no match, with the user-mode boundary just below
    drive(1, 32'h0040_2000, 0, 0, 0, 2'b01, 32'h0080_0000, 32'h0000_0055, "R2");
    drive(1, 32'h0040_2000, 1, 0, 0, 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FF66, "R2");
    drive(1, 32'h7FFF_FFFF, 0, 1, 0, 2'b01, 32'h0000_0000, 32'h0000_0077, "R2");
    // R5: a match holds the registers
    drive(1, 32'h1234_5000, 1, 0, 0, 2'b00, 32'hDEAD_BEEF, 32'hCAFE_F00D, "R5");
    drive(1, 32'h0000_3000, 0, 1, 0, 2'b00, 32'h1111_1111, 32'h2222_2222, "R5");
    // R3: entry not valid
    drive(1, 32'h2468_A000, 0, 0, 0, 2'b10, 32'hC000_0000, 32'h0000_0088, "R3");
    drive(1, 32'h1357_9BDF, 1, 1, 0, 2'b10, 32'h0000_0001, 32'h0000_0099, "R3");
    // R4: clean page in both directions
    drive(1, 32'h0ABC_D000, 1, 0, 0, 2'b11, 32'h5555_5555, 32'h0000_00AA, "R4");
    drive(1, 32'h0ABC_F000, 0, 1, 0, 2'b11, 32'hAAAA_AAAA, 32'h0000_00BB, "R4");
    // R6: error level bypasses translation
    drive(1, 32'h0000_1000, 0, 0, 1, 2'b01, 32'h3333_3333, 32'h4444_4444, "R6");
    drive(1, 32'h7FFF_E000, 1, 1, 1, 2'b11, 32'h6666_6666, 32'h7777_7777, "R6");
    // R7: kernel access to the upper half
    drive(1, 32'h9000_0000, 1, 0, 0, 2'b01, 32'h8888_8888, 32'h9999_9999, "R7");
    drive(1, 32'hC000_0000, 1, 0, 0, 2'b11, 32'hBBBB_BBBB, 32'hCCCC_CCCC, "R7");
    // R10: idle cycles with faulting inputs, then back-to-back faults
    drive(0, 32'h0040_2000, 0, 0, 0, 2'b01, 32'hEEEE_EEEE, 32'hDDDD_DDDD, "R10");
    drive(0, 32'h8000_0000, 1, 1, 0, 2'b00, 32'hEEEE_EEEE, 32'hDDDD_DDDD, "R10");
    drive(1, 32'h0010_0000, 0, 0, 0, 2'b01, 32'h0123_4567, 32'h89AB_CDEF, "R10");
    drive(1, 32'h0020_2000, 1, 0, 0, 2'b10, 32'hFEDC_BA98, 32'h7654_3210, "R8");
    drive(1, 32'hFFFF_E000, 0, 1, 0, 2'b00, 32'hFF80_0000, 32'h0000_00FF, "R9");
    drive(0, 32'h0, 0, 0, 0, 2'b00, 32'h0, 32'h0, "R10");
    drive(0, 32'h0, 0, 0, 0, 2'b00, 32'h0, 32'h0, "R10");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule